// File: doc/BRIEF.md
# Multithreaded Issue Slot Scheduler

This block decides, cycle by cycle, which of several hardware thread contexts may place an instruction into a single-issue pipeline that they all share. Its output is a thread index plus a valid flag. A low valid flag is a bubble. The index is meant to travel down the pipeline next to the issued instruction, so that every later stage reads and writes the right per-thread state.

Three policies are available and are chosen by a mode input:

- **Fixed rotation** hands one slot to each thread in turn.
- **Table-driven** walks a small programmable table of slots, each naming a thread.
- **Ready-driven** grants the first ready thread found by a rotating search.

In both slot-based policies a slot belongs to its owner. If the owner is not ready, the slot is wasted as a bubble and is not passed to anyone else.

The select outputs are combinational in the current ready vector and the scheduler state. A grant therefore reflects readiness in the same cycle.

Top module: `issue_slot_sched`

## Requirements
- R1: A synchronous reset puts the slot counter at 0, the search pointer at thread 0 and the active mode at fixed rotation (code 0), and loads table entry i with thread i mod NUM_THREADS.
- R2: In fixed rotation (mode code 0, and also the spare code 3), the shown thread steps 0, 1, …, NUM_THREADS-1 and then back to 0, advancing by one every cycle.
- R3: In both slot-based modes, issue_valid_o is high exactly when the slot owner's ready_i bit is set. When it is low, issue_tid_o still shows the owner, and no other thread is granted in that slot.
- R4: In table mode (code 1), the shown thread is the table entry at the current slot. Slots run 0 … S-1 and wrap, where S is slot_count_i clamped into 1..TABLE_DEPTH (0 acts as 1, values above TABLE_DEPTH act as TABLE_DEPTH). A counter that reaches or passes S-1 returns to slot 0 on the next cycle.
- R5: With tbl_we_i high at a clock edge, entry tbl_idx_i takes tbl_tid_i. The new value is seen from the next cycle on. Writes are accepted in every mode and are kept.
- R6: In ready-driven mode (code 2), the grant goes to the first ready thread found by scanning upward from the search pointer with wraparound. After a grant, the pointer moves to the granted thread plus one (mod NUM_THREADS).
- R7: In ready-driven mode, a bubble appears only when no thread is ready. During such a bubble, issue_tid_o shows the search pointer and the pointer does not move.
- R8: When mode_i differs from the active mode at a clock edge, the new mode is active in the next cycle with the slot counter at 0. The search pointer is kept across mode changes and is left untouched while a slot-based mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready_i | input | NUM_THREADS | Per-thread ready flags |
| mode_i | input | 2 | Policy code: 0 rotation, 1 table, 2 ready-driven, 3 rotation |
| slot_count_i | input | $clog2(TABLE_DEPTH+1) | Active table slot count S |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | $clog2(TABLE_DEPTH) | Table entry to write |
| tbl_tid_i | input | $clog2(NUM_THREADS) | Thread written into the entry |
| issue_valid_o | output | 1 | Issue this cycle; low means bubble |
| issue_tid_o | output | $clog2(NUM_THREADS) | Selected thread index |

## Verification

The bench sweeps every ready pattern under each policy and compares each cycle against an arithmetic model of slots, table and pointer. Each sweep targets a specific way the scheduler could go wrong:

- **Owner-only slots.** A scheduler that let a ready neighbour steal an unready owner's slot would show a valid grant where a bubble is due.
- **Rotating search.** A fixed-priority search would keep favouring thread 0 in ready-driven mode. A pointer that moved on a bubble would shift the next grant.

Further sequences aim at the remaining corner cases:

- **Slot count.** The count is swept through 0 and past the table depth, and shrunk below the current slot, where a wrong wrap or a missing clamp sends the walk through stale entries.
- **Table writes.** Entries are rewritten during operation and while another mode is active, which catches early visibility or dropped writes.
- **Mode switches.** Switches, including between the two rotation codes, would reveal a counter that keeps its old slot.
- **Mid-run reset.** A reset in the middle of a run checks that the table returns to its default contents.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'd0,
    POL_TABLE  = 2'd1,
    POL_READY  = 2'd2,
    POL_SPARE  = 2'd3
  } policy_e;

  // Effective slot count: a request of zero acts as one, above depth acts as depth.
  function automatic int clamp_slots(input int req, input int depth);
    if (req < 1) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

  // Next slot index: wraps to zero once the last active slot is reached or passed.
  function automatic int slot_advance(input int cur, input int lim);
    if (cur + 1 >= lim) return 0;
    return cur + 1;
  endfunction

  // Thread after v in a ring of n threads.
  function automatic int ring_next(input int v, input int n);
    return (v + 1) % n;
  endfunction

endpackage

// File: rtl/sched_slot_ctr.sv
module sched_slot_ctr #(
  parameter int CTR_W = 3,
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [CTR_W-1:0] slot_o
);

  logic [CTR_W-1:0] slot_q;
  logic [CTR_W-1:0] slot_d;

  always_comb begin
    if (restart_i || hold_i) slot_d = '0;
    else slot_d = CTR_W'(sched_pkg::slot_advance(int'(slot_q), int'(limit_i)));
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_d;
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/sched_slot_table.sv
module sched_slot_table #(
  parameter int NUM_THREADS = 4,
  parameter int TABLE_DEPTH = 8,
  parameter int TID_W       = 2,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TID_W-1:0] wtid_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [TID_W-1:0] rtid_o
);

  logic [TABLE_DEPTH-1:0][TID_W-1:0] entries;

  for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_entry
    logic [TID_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) val_q <= TID_W'(g % NUM_THREADS);
      else if (we_i && (widx_i == IDX_W'(g))) val_q <= wtid_i;
    end
    assign entries[g] = val_q;
  end

  assign rtid_o = entries[ridx_i];

endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [TID_W-1:0]       start_i,
  output logic                   pick_valid_o,
  output logic [TID_W-1:0]       pick_tid_o
);

  logic [TID_W-1:0] probe;

  // Scan from the farthest offset down so the nearest ready thread wins.
  always_comb begin
    pick_valid_o = 1'b0;
    pick_tid_o   = '0;
    probe        = '0;
    for (int k = NUM_THREADS - 1; k >= 0; k--) begin
      probe = TID_W'((int'(start_i) + k) % NUM_THREADS);
      if (ready_i[probe]) begin
        pick_valid_o = 1'b1;
        pick_tid_o   = probe;
      end
    end
  end

endmodule

// File: rtl/issue_slot_sched.sv
module issue_slot_sched #(
  parameter int NUM_THREADS = 4,
  parameter int TABLE_DEPTH = 8,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W  = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1,
  localparam int SCNT_W = $clog2(TABLE_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [1:0]             mode_i,
  input  logic [SCNT_W-1:0]      slot_count_i,
  input  logic                   tbl_we_i,
  input  logic [IDX_W-1:0]       tbl_idx_i,
  input  logic [TID_W-1:0]       tbl_tid_i,
  output logic                   issue_valid_o,
  output logic [TID_W-1:0]       issue_tid_o
);
  import sched_pkg::*;

  localparam int SPAN  = (NUM_THREADS > TABLE_DEPTH) ? NUM_THREADS : TABLE_DEPTH;
  localparam int CTR_W = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int LIM_W = $clog2(SPAN + 1);

  // Named internal events, observed by the bound checker.
  logic [1:0]       mode_q;
  logic             mode_change;
  logic             rotate_mode;
  logic             table_mode;
  logic             ready_mode;
  logic [CTR_W-1:0] slot_q;
  logic [LIM_W-1:0] slot_limit;
  logic [TID_W-1:0] ptr_q;
  logic [TID_W-1:0] tbl_owner;
  logic [TID_W-1:0] slot_owner;
  logic             pick_valid;
  logic [TID_W-1:0] pick_tid;

  assign mode_change = (mode_i != mode_q);
  assign table_mode  = (mode_q == POL_TABLE);
  assign ready_mode  = (mode_q == POL_READY);
  assign rotate_mode = !table_mode && !ready_mode;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= POL_ROTATE;
    else     mode_q <= mode_i;
  end

  always_comb begin
    if (table_mode) slot_limit = LIM_W'(clamp_slots(int'(slot_count_i), TABLE_DEPTH));
    else            slot_limit = LIM_W'(NUM_THREADS);
  end

  sched_slot_ctr #(
    .CTR_W (CTR_W),
    .LIM_W (LIM_W)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .restart_i (mode_change),
    .hold_i    (ready_mode),
    .limit_i   (slot_limit),
    .slot_o    (slot_q)
  );

  sched_slot_table #(
    .NUM_THREADS (NUM_THREADS),
    .TABLE_DEPTH (TABLE_DEPTH),
    .TID_W       (TID_W),
    .IDX_W       (IDX_W)
  ) u_table (
    .clk    (clk),
    .rst    (rst),
    .we_i   (tbl_we_i),
    .widx_i (tbl_idx_i),
    .wtid_i (tbl_tid_i),
    .ridx_i (slot_q[IDX_W-1:0]),
    .rtid_o (tbl_owner)
  );

  sched_rr_pick #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
  ) u_pick (
    .ready_i      (ready_i),
    .start_i      (ptr_q),
    .pick_valid_o (pick_valid),
    .pick_tid_o   (pick_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (ready_mode && pick_valid)
      ptr_q <= TID_W'(ring_next(int'(pick_tid), NUM_THREADS));
  end

  assign slot_owner = table_mode ? tbl_owner : TID_W'(slot_q);

  always_comb begin
    if (ready_mode) begin
      issue_valid_o = pick_valid;
      issue_tid_o   = pick_valid ? pick_tid : ptr_q;
    end else begin
      issue_valid_o = ready_i[slot_owner];
      issue_tid_o   = slot_owner;
    end
  end

endmodule

// File: rtl/issue_slot_sched_chk.sv
module issue_slot_sched_chk #(
  parameter int NUM_THREADS = 4,
  parameter int TABLE_DEPTH = 8,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SPAN  = (NUM_THREADS > TABLE_DEPTH) ? NUM_THREADS : TABLE_DEPTH,
  localparam int CTR_W = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int LIM_W = $clog2(SPAN + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] ready_i,
  input logic                   issue_valid_o,
  input logic [TID_W-1:0]       issue_tid_o,
  input logic [1:0]             mode_q,
  input logic                   mode_change,
  input logic                   rotate_mode,
  input logic [CTR_W-1:0]       slot_q,
  input logic [LIM_W-1:0]       slot_limit,
  input logic [TID_W-1:0]       ptr_q
);
  import sched_pkg::*;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    !past_ok |-> (slot_q == '0 && ptr_q == '0 && mode_q == POL_ROTATE)); // R1

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rotate_mode && !$past(mode_change))
      |-> int'(issue_tid_o) == (int'($past(issue_tid_o)) + 1) % NUM_THREADS); // R2

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o |-> ready_i[issue_tid_o]); // R3

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (int'(slot_q) + 1 >= int'(slot_limit)) |=> slot_q == '0); // R4

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode_q) == POL_READY && $past(issue_valid_o))
      |-> int'(ptr_q) == (int'($past(issue_tid_o)) + 1) % NUM_THREADS); // R6

  AST_HW_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == POL_READY && |ready_i) |-> issue_valid_o); // R7

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (rst)
    mode_change |=> slot_q == '0); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode_q) != POL_READY) |-> $stable(ptr_q)); // R8

endmodule

bind issue_slot_sched issue_slot_sched_chk #(
  .NUM_THREADS (NUM_THREADS),
  .TABLE_DEPTH (TABLE_DEPTH)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ready_i       (ready_i),
  .issue_valid_o (issue_valid_o),
  .issue_tid_o   (issue_tid_o),
  .mode_q        (mode_q),
  .mode_change   (mode_change),
  .rotate_mode   (rotate_mode),
  .slot_q        (slot_q),
  .slot_limit    (slot_limit),
  .ptr_q         (ptr_q)
);

// File: tb/issue_slot_sched_bench.sv
module issue_slot_sched_bench;
  localparam int NT = 4;
  localparam int TD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ready = '0;
  logic [1:0] mode = 2'd0;
  logic [3:0] scount = 4'd8;
  logic       we = 1'b0;
  logic [2:0] widx = '0;
  logic [1:0] wtid = '0;
  logic       issue_valid;
  logic [1:0] issue_tid;

  always #4 clk = ~clk;

  issue_slot_sched u_issue_slot_sched (
    .clk           (clk),
    .rst           (rst),
    .ready_i       (ready),
    .mode_i        (mode),
    .slot_count_i  (scount),
    .tbl_we_i      (we),
    .tbl_idx_i     (widx),
    .tbl_tid_i     (wtid),
    .issue_valid_o (issue_valid),
    .issue_tid_o   (issue_tid)
  );

  int checks = 0;
  int errors = 0;

  // Reference state derived from the requirements.
  int m_slot, m_ptr, m_mode;
  int m_tbl[TD];
  bit ev;
  int et;

  function automatic int eff_slots(input int s);
    return (s == 0) ? 1 : ((s > TD) ? TD : s);
  endfunction

  function void predict();
    int owner;
    ev = 1'b0;
    if (m_mode == 2) begin
      et = m_ptr;
      for (int k = NT - 1; k >= 0; k--)
        if (ready[(m_ptr + k) % NT]) begin ev = 1'b1; et = (m_ptr + k) % NT; end
    end else begin
      owner = (m_mode == 1) ? m_tbl[m_slot] : m_slot;
      ev = ready[owner];
      et = owner;
    end
  endfunction

  function void advance();
    int lim;
    if (rst) begin
      m_slot = 0; m_ptr = 0; m_mode = 0;
      for (int i = 0; i < TD; i++) m_tbl[i] = i % NT;
    end else begin
      if (m_mode == 2 && ev) m_ptr = (et + 1) % NT;
      if (we) m_tbl[widx] = int'(wtid);
      if (int'(mode) != m_mode) begin
        m_mode = int'(mode); m_slot = 0;
      end else if (m_mode == 2) begin
        m_slot = 0;
      end else begin
        lim = (m_mode == 1) ? eff_slots(int'(scount)) : NT;
        m_slot = (m_slot + 1 >= lim) ? 0 : m_slot + 1;
      end
    end
  endfunction

  task automatic tick(input string tag, input bit chk);
    #1;
    predict();
    if (chk) begin
      checks++;
      if ({issue_valid, issue_tid} !== {ev, 2'(et)}) begin
        errors++;
        $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                 tag, issue_valid, issue_tid, ev, et);
      end
    end
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick("", 1'b0);
    tick("", 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R1: state right after reset, fixed rotation from thread 0
    ready = 4'hF;
    tick("R1", 1'b1);

    // R2 / R3: fixed rotation over every ready pattern
    for (int p = 0; p < 16; p++) begin
      ready = 4'(p);
      for (int c = 0; c < 4; c++) tick((p == 15) ? "R2" : "R3", 1'b1);
    end

    // R2: spare code 3 also rotates; R8 restart on the change
    ready = 4'hF;
    mode = 2'd3;
    tick("R8", 1'b1);
    for (int c = 0; c < 8; c++) tick("R2", 1'b1);

    // R1: default table contents walked in table mode
    mode = 2'd1;
    scount = 4'd8;
    tick("R8", 1'b1);
    for (int c = 0; c < 8; c++) tick("R1", 1'b1);

    // R5: rewrite every entry while running, then walk the new table
    for (int i = 0; i < TD; i++) begin
      we = 1'b1; widx = 3'(i); wtid = 2'((3 * i + 1) % NT);
      tick("R5", 1'b1);
    end
    we = 1'b0;
    for (int c = 0; c < 16; c++) tick("R5", 1'b1);

    // R4: slot count sweep including 0 and values past the depth
    for (int s = 0; s < 11; s++) begin
      scount = 4'(s);
      for (int c = 0; c < 12; c++) tick("R4", 1'b1);
    end

    // R3: table mode with every ready pattern
    scount = 4'd5;
    for (int p = 0; p < 16; p++) begin
      ready = 4'(p);
      for (int c = 0; c < 3; c++) tick("R3", 1'b1);
    end

    // R6 / R7: ready-driven mode over every ready pattern
    mode = 2'd2;
    for (int p = 0; p < 16; p++) begin
      ready = 4'(p);
      for (int c = 0; c < 5; c++) tick((p == 0) ? "R7" : "R6", 1'b1);
    end
    ready = 4'b1010;
    for (int c = 0; c < 3; c++) tick("R6", 1'b1);

    // R8 / R5: pointer kept over a slot-mode detour; write while rotating
    mode = 2'd0;
    ready = 4'hF;
    we = 1'b1; widx = 3'd0; wtid = 2'd3;
    tick("R8", 1'b1);
    we = 1'b0;
    for (int c = 0; c < 5; c++) tick("R8", 1'b1);
    mode = 2'd2;
    ready = 4'b0111;
    for (int c = 0; c < 6; c++) tick("R8", 1'b1);
    mode = 2'd1;
    scount = 4'd8;
    ready = 4'hF;
    for (int c = 0; c < 4; c++) tick("R5", 1'b1);

    // R1: reset in mid-run restores the default table
    do_reset();
    mode = 2'd1;
    for (int c = 0; c < 10; c++) tick("R1", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule